// File: doc/BRIEF.md
# Serial-Management Board Control Registers

This block is a management-bus responder for board housekeeping. It watches a management clock and a bidirectional data line from a host. It decodes read and write frames and serves a small space of 16-bit registers. The 5-bit device field and the 5-bit register field of each frame are joined into a 10-bit word address, so each device value selects a page of 32 registers.

Most registers are read-only. They report identity values (product, logic version, board and SoC revision, serial number), the raw levels of two DIP switch banks and the mode value the board has actually applied. The writable registers drive outputs: a 32-bit requested mode, power and peripheral configuration words, and an LED word. A write to the reset register starts a board-reset pulse with a length set by a parameter.

The management clock and data are synchronised into the system clock domain. Every frame decision is made on a detected rising edge of the management clock.

Top module: `mdio_board_ctl`

## Requirements
- R1: The word address is the frame's device field times 32 plus its register field; device 0x18 with register 0x01 reaches word 0x301.
- R2: Word 0x000 reads product ID bits 15:0 and 0x001 reads bits 31:16. Word 0x002 reads logic version bits 15:0 and 0x003 reads bits 31:16.
- R3: Words 0x004 (bits 15:0) and 0x005 (bits 31:16) are read/write and drive `mode_set`. Words 0x006/0x007 read the low and high halves of `mode_applied`.
- R4: Words 0x00B, 0x00C, 0x00D and 0x00E are read/write. They drive `power_cfg`, `periph_cfg_a`, `periph_cfg_b` and `leds`, in that order.
- R5: Word 0x008 reads `dip_bank8_n` in bits 7:0 and `dip_bank4_n` in bits 11:8, with the raw active-low levels and zeros in bits 15:12.
- R6: A write to word 0x00A with data bit 0 set raises `board_reset` for exactly RST_PULSE_CYCLES clock cycles, starting the cycle after the write commits. A write with bit 0 clear gives no pulse. Word 0x00A reads 0x0000.
- R7: Words 0x300, 0x301, 0x302 and 0x303 read `pcb_version`, `soc_version`, `serial_no` bits 15:0 and `serial_no` bits 31:16.
- R8: In a read frame (opcode bits 1 then 0), MDIO is released during the first turnaround bit and driven 0 after the second turnaround rising edge. The 16 data bits follow MSB first, each changing after an MDC rising edge. The line is released after the next edge.
- R9: In a write frame (opcode bits 0 then 1), the two turnaround bits are not checked. The 16 data bits are sampled MSB first on MDC rising edges and committed after the last bit.
- R10: Reads of unmapped words return 0x0000. Writes to read-only or unmapped words change no register.
- R11: A frame is accepted only after at least PREAMBLE_BITS consecutive 1 bits. A start field other than 0 then 1, or an opcode of 00 or 11, makes the rest of the frame be ignored until a new preamble, and MDIO stays released.
- R12: After reset, `mode_set` equals MODE_RESET, all other configuration outputs are 0, and `board_reset` and `mdio_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data value driven during read turnaround and data |
| mdio_oe | output | 1 | Output enable for the data line |
| board_reset | output | 1 | Board reset pulse, active high |
| mode_set | output | 32 | Requested mode word |
| power_cfg | output | 16 | Power configuration word |
| periph_cfg_a | output | 16 | First peripheral configuration word |
| periph_cfg_b | output | 16 | Second peripheral configuration word |
| leds | output | 16 | LED control word |
| product_id | input | 32 | Product identifier |
| logic_version | input | 32 | Logic version value |
| mode_applied | input | 32 | Mode value applied by the board |
| dip_bank8_n | input | 8 | Eight-way switch bank, active low |
| dip_bank4_n | input | 4 | Four-way switch bank, active low |
| pcb_version | input | 16 | Board revision |
| soc_version | input | 16 | SoC revision |
| serial_no | input | 32 | Board serial number |

## Verification
The bench uses the default 32-bit preamble and synchroniser depth. This lets it place a short 20-bit preamble and aborted frames whose ones could otherwise add up into a false preamble. RST_PULSE_CYCLES is lowered to 12, so the whole reset pulse finishes inside one frame's tail and its exact length can be counted cycle by cycle. MODE_RESET stays 0, so the reset value of `mode_set` is simple to predict.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  localparam int WORD_W = 16;
  localparam int FIELD_W = 5;
  localparam int WADDR_W = 2 * FIELD_W;

  typedef enum logic [2:0] {
    PH_PRE, PH_ST, PH_OP, PH_ADDR, PH_TA, PH_DATA, PH_TAIL
  } phase_e;

  localparam logic [WADDR_W-1:0] ADR_PROD_LO  = 10'h000;
  localparam logic [WADDR_W-1:0] ADR_PROD_HI  = 10'h001;
  localparam logic [WADDR_W-1:0] ADR_LVER_LO  = 10'h002;
  localparam logic [WADDR_W-1:0] ADR_LVER_HI  = 10'h003;
  localparam logic [WADDR_W-1:0] ADR_MODE_LO  = 10'h004;
  localparam logic [WADDR_W-1:0] ADR_MODE_HI  = 10'h005;
  localparam logic [WADDR_W-1:0] ADR_APPL_LO  = 10'h006;
  localparam logic [WADDR_W-1:0] ADR_APPL_HI  = 10'h007;
  localparam logic [WADDR_W-1:0] ADR_SWITCH   = 10'h008;
  localparam logic [WADDR_W-1:0] ADR_RESET    = 10'h00A;
  localparam logic [WADDR_W-1:0] ADR_POWER    = 10'h00B;
  localparam logic [WADDR_W-1:0] ADR_PERI_A   = 10'h00C;
  localparam logic [WADDR_W-1:0] ADR_PERI_B   = 10'h00D;
  localparam logic [WADDR_W-1:0] ADR_LEDS     = 10'h00E;
  localparam logic [WADDR_W-1:0] ADR_PCB      = 10'h300;
  localparam logic [WADDR_W-1:0] ADR_SOC      = 10'h301;
  localparam logic [WADDR_W-1:0] ADR_SN_LO    = 10'h302;
  localparam logic [WADDR_W-1:0] ADR_SN_HI    = 10'h303;

  // page (device field) selects a block of 32 words
  function automatic logic [WADDR_W-1:0] join_addr(input logic [FIELD_W-1:0] page,
                                                   input logic [FIELD_W-1:0] word);
    return {page, word};
  endfunction

  function automatic logic is_writable(input logic [WADDR_W-1:0] a);
    return (a == ADR_MODE_LO) || (a == ADR_MODE_HI) || (a == ADR_RESET) ||
           (a == ADR_POWER) || (a == ADR_PERI_A) || (a == ADR_PERI_B) ||
           (a == ADR_LEDS);
  endfunction

  // opcode field: 2'b10 read, 2'b01 write
  function automatic logic op_valid(input logic hi, input logic lo);
    return hi ^ lo;
  endfunction
endpackage

// File: rtl/mdc_edge.sv
module mdc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic bit_rise,
  output logic bit_val
);
  logic [SYNC_STAGES-1:0] mdc_pipe;
  logic [SYNC_STAGES-1:0] dat_pipe;
  logic                   mdc_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mdc_pipe <= '0;
          dat_pipe <= '1;
        end else begin
          mdc_pipe <= mdc;
          dat_pipe <= mdio_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mdc_pipe <= '0;
          dat_pipe <= '1;
        end else begin
          mdc_pipe <= {mdc_pipe[SYNC_STAGES-2:0], mdc};
          dat_pipe <= {dat_pipe[SYNC_STAGES-2:0], mdio_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_prev <= 1'b0;
    else        mdc_prev <= mdc_pipe[SYNC_STAGES-1];
  end

  assign bit_rise = mdc_pipe[SYNC_STAGES-1] & ~mdc_prev;
  assign bit_val  = dat_pipe[SYNC_STAGES-1];

  AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rise |=> !bit_rise); // R8
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import board_ctl_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_rise,
  input  logic               bit_val,
  input  logic [WORD_W-1:0]  rd_data,
  output logic [WADDR_W-1:0] acc_addr,
  output logic               wr_en,
  output logic [WORD_W-1:0]  wr_data,
  output logic               mdio_o,
  output logic               mdio_oe
);
  localparam int CNT_MAX = (PRE_LEN > WORD_W) ? PRE_LEN : WORD_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PRE_TOP  = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] DATA_TOP = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ADDR_TOP = CNT_W'(WADDR_W - 1);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic               op_hi;
  logic               is_read;
  logic [WADDR_W-1:0] addr_sh;
  logic [WORD_W-1:0]  rx_sh;
  logic [WORD_W-1:0]  tx_sh;

  logic [WADDR_W-1:0] addr_nxt;
  logic [WORD_W-1:0]  rx_nxt;
  logic               pre_full;
  logic               ev_frame_start;
  logic               ev_abort;
  logic               ev_addr_done;
  logic               ev_write_commit;

  assign addr_nxt = {addr_sh[WADDR_W-2:0], bit_val};
  assign rx_nxt   = {rx_sh[WORD_W-2:0], bit_val};
  assign pre_full = (cnt >= PRE_TOP);

  assign ev_frame_start  = bit_rise && (phase == PH_PRE) && !bit_val && pre_full;
  assign ev_abort        = bit_rise && (((phase == PH_ST) && !bit_val) ||
                           ((phase == PH_OP) && (cnt != '0) && !op_valid(op_hi, bit_val)));
  assign ev_addr_done    = bit_rise && (phase == PH_ADDR) && (cnt == ADDR_TOP);
  assign ev_write_commit = bit_rise && (phase == PH_DATA) && !is_read && (cnt == DATA_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_PRE;
      cnt      <= '0;
      op_hi    <= 1'b0;
      is_read  <= 1'b0;
      addr_sh  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      acc_addr <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      mdio_o   <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (bit_rise) begin
        unique case (phase)
          PH_PRE: begin
            if (bit_val) begin
              if (!pre_full) cnt <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              if (ev_frame_start) phase <= PH_ST;
            end
          end
          PH_ST: begin
            cnt   <= '0;
            phase <= bit_val ? PH_OP : PH_PRE;
          end
          PH_OP: begin
            if (cnt == '0) begin
              op_hi <= bit_val;
              cnt   <= cnt + 1'b1;
            end else begin
              cnt     <= '0;
              is_read <= op_hi & ~bit_val;
              phase   <= ev_abort ? PH_PRE : PH_ADDR;
            end
          end
          PH_ADDR: begin
            addr_sh <= addr_nxt;
            if (ev_addr_done) begin
              acc_addr <= join_addr(addr_nxt[WADDR_W-1:FIELD_W], addr_nxt[FIELD_W-1:0]);
              cnt      <= '0;
              phase    <= PH_TA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_TA: begin
            if (cnt == '0) begin
              cnt <= cnt + 1'b1;
              if (is_read) tx_sh <= rd_data;
            end else begin
              cnt   <= '0;
              phase <= PH_DATA;
              if (is_read) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end
          end
          PH_DATA: begin
            if (is_read) begin
              mdio_o <= tx_sh[WORD_W-1];
              tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
            end else begin
              rx_sh <= rx_nxt;
            end
            if (cnt == DATA_TOP) begin
              cnt   <= '0;
              phase <= is_read ? PH_TAIL : PH_PRE;
              if (ev_write_commit) begin
                wr_en   <= 1'b1;
                wr_data <= rx_nxt;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_TAIL: begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
            cnt     <= '0;
            phase   <= PH_PRE;
          end
          default: phase <= PH_PRE;
        endcase
      end
    end
  end

  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!mdio_oe && !wr_en)); // R11
  AST_TA_DRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R8
  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> is_read); // R8
  AST_WRITE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R9
  AST_WRITE_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mdio_oe); // R9
endmodule

// File: rtl/board_regs.sv
module board_regs
  import board_ctl_pkg::*;
#(
  parameter logic [31:0] MODE_RESET = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [WADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0]  rd_data,
  input  logic [31:0]        product_id,
  input  logic [31:0]        logic_version,
  input  logic [31:0]        mode_applied,
  input  logic [7:0]         dip_bank8_n,
  input  logic [3:0]         dip_bank4_n,
  input  logic [15:0]        pcb_version,
  input  logic [15:0]        soc_version,
  input  logic [31:0]        serial_no,
  output logic [31:0]        mode_set,
  output logic [WORD_W-1:0]  power_cfg,
  output logic [WORD_W-1:0]  periph_cfg_a,
  output logic [WORD_W-1:0]  periph_cfg_b,
  output logic [WORD_W-1:0]  leds,
  output logic               rst_trig
);
  logic [WORD_W-1:0] mode_lo, mode_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lo      <= MODE_RESET[15:0];
      mode_hi      <= MODE_RESET[31:16];
      power_cfg    <= '0;
      periph_cfg_a <= '0;
      periph_cfg_b <= '0;
      leds         <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADR_MODE_LO: mode_lo      <= wr_data;
        ADR_MODE_HI: mode_hi      <= wr_data;
        ADR_POWER:   power_cfg    <= wr_data;
        ADR_PERI_A:  periph_cfg_a <= wr_data;
        ADR_PERI_B:  periph_cfg_b <= wr_data;
        ADR_LEDS:    leds         <= wr_data;
        default: ;
      endcase
    end
  end

  assign mode_set = {mode_hi, mode_lo};
  assign rst_trig = wr_en && (wr_addr == ADR_RESET) && wr_data[0];

  always_comb begin
    unique case (rd_addr)
      ADR_PROD_LO: rd_data = product_id[15:0];
      ADR_PROD_HI: rd_data = product_id[31:16];
      ADR_LVER_LO: rd_data = logic_version[15:0];
      ADR_LVER_HI: rd_data = logic_version[31:16];
      ADR_MODE_LO: rd_data = mode_lo;
      ADR_MODE_HI: rd_data = mode_hi;
      ADR_APPL_LO: rd_data = mode_applied[15:0];
      ADR_APPL_HI: rd_data = mode_applied[31:16];
      ADR_SWITCH:  rd_data = {4'h0, dip_bank4_n, dip_bank8_n};
      ADR_POWER:   rd_data = power_cfg;
      ADR_PERI_A:  rd_data = periph_cfg_a;
      ADR_PERI_B:  rd_data = periph_cfg_b;
      ADR_LEDS:    rd_data = leds;
      ADR_PCB:     rd_data = pcb_version;
      ADR_SOC:     rd_data = soc_version;
      ADR_SN_LO:   rd_data = serial_no[15:0];
      ADR_SN_HI:   rd_data = serial_no[31:16];
      default:     rd_data = '0;
    endcase
  end

  AST_READONLY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_writable(wr_addr)) |=> ($stable(mode_set) && $stable(power_cfg) &&
      $stable(periph_cfg_a) && $stable(periph_cfg_b) && $stable(leds))); // R10
  AST_LED_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADR_LEDS)) |=> (leds == $past(wr_data))); // R4
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_set)); // R3
endmodule

// File: rtl/reset_pulse.sv
module reset_pulse #(
  parameter int PULSE_LEN = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic board_reset
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LEN = CW'(PULSE_LEN);

  logic [CW-1:0] remain;
  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (trig)         remain <= LEN;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign board_reset = (remain != '0);

  // cycles elapsed inside the current pulse, for the length check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_len <= '0;
    else if (trig)        run_len <= '0;
    else if (board_reset) run_len <= run_len + 1'b1;
  end

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> board_reset); // R6
  AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    board_reset |-> (run_len < LEN)); // R6
endmodule

// File: rtl/mdio_board_ctl.sv
module mdio_board_ctl
  import board_ctl_pkg::*;
#(
  parameter int          PREAMBLE_BITS    = 32,
  parameter int          SYNC_STAGES      = 2,
  parameter int          RST_PULSE_CYCLES = 1000,
  parameter logic [31:0] MODE_RESET       = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        board_reset,
  output logic [31:0] mode_set,
  output logic [15:0] power_cfg,
  output logic [15:0] periph_cfg_a,
  output logic [15:0] periph_cfg_b,
  output logic [15:0] leds,
  input  logic [31:0] product_id,
  input  logic [31:0] logic_version,
  input  logic [31:0] mode_applied,
  input  logic [7:0]  dip_bank8_n,
  input  logic [3:0]  dip_bank4_n,
  input  logic [15:0] pcb_version,
  input  logic [15:0] soc_version,
  input  logic [31:0] serial_no
);
  logic               bit_rise, bit_val;
  logic [WADDR_W-1:0] acc_addr;
  logic               wr_en;
  logic [WORD_W-1:0]  wr_data, rd_data;
  logic               rst_trig;

  mdc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
    .bit_rise(bit_rise), .bit_val(bit_val)
  );

  mdio_frame #(.PRE_LEN(PREAMBLE_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_val(bit_val),
    .rd_data(rd_data), .acc_addr(acc_addr), .wr_en(wr_en), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  board_regs #(.MODE_RESET(MODE_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(acc_addr), .wr_data(wr_data),
    .rd_addr(acc_addr), .rd_data(rd_data),
    .product_id(product_id), .logic_version(logic_version), .mode_applied(mode_applied),
    .dip_bank8_n(dip_bank8_n), .dip_bank4_n(dip_bank4_n),
    .pcb_version(pcb_version), .soc_version(soc_version), .serial_no(serial_no),
    .mode_set(mode_set), .power_cfg(power_cfg), .periph_cfg_a(periph_cfg_a),
    .periph_cfg_b(periph_cfg_b), .leds(leds), .rst_trig(rst_trig)
  );

  reset_pulse #(.PULSE_LEN(RST_PULSE_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .trig(rst_trig), .board_reset(board_reset)
  );
endmodule

// File: tb/sim_mdio_board_ctl.sv
`timescale 1ns/1ps
module sim_mdio_board_ctl;
  localparam int PULSE = 12;
  localparam int NV = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic host_drv = 1'b0;
  logic host_val = 1'b1;
  logic mdio_o, mdio_oe, board_reset;
  logic [31:0] mode_set;
  logic [15:0] power_cfg, periph_cfg_a, periph_cfg_b, leds;
  logic mdio_bus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int rst_high = 0;
  int rst_rises = 0;
  logic rst_prev = 1'b0;
  bit oe_seen = 1'b0;

  always #2.5 clk = ~clk;

  assign mdio_bus = mdio_oe ? mdio_o : (host_drv ? host_val : 1'b1);

  mdio_board_ctl #(.PREAMBLE_BITS(32), .SYNC_STAGES(2), .RST_PULSE_CYCLES(PULSE),
                   .MODE_RESET(32'h0)) u0 (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_bus),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .board_reset(board_reset),
    .mode_set(mode_set), .power_cfg(power_cfg), .periph_cfg_a(periph_cfg_a),
    .periph_cfg_b(periph_cfg_b), .leds(leds),
    .product_id(32'hA5C3_1F20), .logic_version(32'h2024_0611),
    .mode_applied(32'h5A00_1234), .dip_bank8_n(8'h3C), .dip_bank4_n(4'h9),
    .pcb_version(16'h0102), .soc_version(16'h0301), .serial_no(32'h0001_E240)
  );

  always @(negedge clk) begin
    if (board_reset) rst_high++;
    if (board_reset && !rst_prev) rst_rises++;
    rst_prev = board_reset;
    if (mdio_oe) oe_seen = 1'b1;
  end

  // {write, word address, write data, expected read data}
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 10'h000, 16'h0000, 16'h1F20}, {1'b0, 10'h001, 16'h0000, 16'hA5C3},
    {1'b0, 10'h002, 16'h0000, 16'h0611}, {1'b0, 10'h003, 16'h0000, 16'h2024},
    {1'b1, 10'h004, 16'hDEAD, 16'h0000}, {1'b1, 10'h005, 16'hBEEF, 16'h0000},
    {1'b0, 10'h004, 16'h0000, 16'hDEAD}, {1'b0, 10'h005, 16'h0000, 16'hBEEF},
    {1'b0, 10'h006, 16'h0000, 16'h1234}, {1'b0, 10'h007, 16'h0000, 16'h5A00},
    {1'b0, 10'h008, 16'h0000, 16'h093C},
    {1'b1, 10'h00B, 16'h1111, 16'h0000}, {1'b1, 10'h00C, 16'h2222, 16'h0000},
    {1'b1, 10'h00D, 16'h3333, 16'h0000}, {1'b1, 10'h00E, 16'h00A5, 16'h0000},
    {1'b0, 10'h00B, 16'h0000, 16'h1111}, {1'b0, 10'h00C, 16'h0000, 16'h2222},
    {1'b0, 10'h00D, 16'h0000, 16'h3333}, {1'b0, 10'h00E, 16'h0000, 16'h00A5},
    {1'b1, 10'h000, 16'hFFFF, 16'h0000}, {1'b0, 10'h000, 16'h0000, 16'h1F20},
    {1'b1, 10'h007, 16'hFFFF, 16'h0000}, {1'b0, 10'h007, 16'h0000, 16'h5A00},
    {1'b1, 10'h300, 16'hFFFF, 16'h0000}, {1'b0, 10'h300, 16'h0000, 16'h0102},
    {1'b0, 10'h301, 16'h0000, 16'h0301}, {1'b0, 10'h302, 16'h0000, 16'hE240},
    {1'b0, 10'h303, 16'h0000, 16'h0001}, {1'b0, 10'h009, 16'h0000, 16'h0000},
    {1'b1, 10'h009, 16'h7777, 16'h0000}, {1'b0, 10'h009, 16'h0000, 16'h0000},
    {1'b0, 10'h1FF, 16'h0000, 16'h0000}, {1'b0, 10'h00A, 16'h0000, 16'h0000}
  };

  function automatic string tag_of(input logic [9:0] a);
    if (a <= 10'h003) return "R2 R10";
    if (a <= 10'h007) return "R3 R10";
    if (a == 10'h008) return "R5";
    if (a == 10'h00A) return "R6";
    if (a >= 10'h00B && a <= 10'h00E) return "R4";
    if (a >= 10'h300 && a <= 10'h303) return "R1 R7 R10";
    return "R10";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic drv, input logic v, output logic s, output logic oe_s);
    @(negedge clk);
    host_drv = drv;
    host_val = v;
    mdc = 1'b0;
    repeat (8) @(negedge clk);
    mdc = 1'b1;
    repeat (6) @(negedge clk);
    s = mdio_bus;
    oe_s = mdio_oe;
    @(negedge clk);
  endtask

  task automatic send_hdr(input int npre, input logic [1:0] st, input logic [1:0] op,
                          input logic [9:0] a);
    logic s, o;
    for (int i = 0; i < npre; i++) clk_bit(1'b1, 1'b1, s, o);
    for (int i = 1; i >= 0; i--) clk_bit(1'b1, st[i], s, o);
    for (int i = 1; i >= 0; i--) clk_bit(1'b1, op[i], s, o);
    for (int i = 9; i >= 0; i--) clk_bit(1'b1, a[i], s, o);
  endtask

  task automatic write_frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                             input logic [9:0] a, input logic [15:0] d);
    logic s, o;
    send_hdr(npre, st, op, a);
    clk_bit(1'b1, 1'b1, s, o);
    clk_bit(1'b1, 1'b0, s, o);
    for (int i = 15; i >= 0; i--) clk_bit(1'b1, d[i], s, o);
    clk_bit(1'b0, 1'b1, s, o);
  endtask

  task automatic read_frame(input logic [9:0] a, output logic [15:0] q, output bit ta_ok);
    logic s, o;
    send_hdr(32, 2'b01, 2'b10, a);
    clk_bit(1'b0, 1'b1, s, o);
    ta_ok = !o;
    clk_bit(1'b0, 1'b1, s, o);
    ta_ok = ta_ok && o && !s;
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0, 1'b1, s, o);
      q[i] = s;
    end
    clk_bit(1'b0, 1'b1, s, o);
    ta_ok = ta_ok && !o;
    clk_bit(1'b0, 1'b1, s, o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    bit ta_ok;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12: reset state
    chk(mode_set == 32'h0, "R12", mode_set, 32'h0);
    chk({power_cfg, periph_cfg_a} == 32'h0 && {periph_cfg_b, leds} == 32'h0, "R12",
        {leds, power_cfg}, 32'h0);
    chk(!board_reset && !mdio_oe, "R12", {board_reset, mdio_oe}, 0);

    for (int n = 0; n < NV; n++) begin
      if (VEC[n][42]) begin
        write_frame(32, 2'b01, 2'b01, VEC[n][41:32], VEC[n][31:16]);
      end else begin
        read_frame(VEC[n][41:32], q, ta_ok);
        chk(q == VEC[n][15:0], tag_of(VEC[n][41:32]), q, VEC[n][15:0]);
        chk(ta_ok, "R8 turnaround", ta_ok, 1);
      end
    end

    // R3 R4 R9: outputs follow the written words, untouched by read-only writes (R10)
    chk(mode_set == 32'hBEEF_DEAD, "R3 R9 R10", mode_set, 32'hBEEF_DEAD);
    chk(power_cfg == 16'h1111, "R4", power_cfg, 16'h1111);
    chk(periph_cfg_a == 16'h2222, "R4", periph_cfg_a, 16'h2222);
    chk(periph_cfg_b == 16'h3333, "R4", periph_cfg_b, 16'h3333);
    chk(leds == 16'h00A5, "R4 R10", leds, 16'h00A5);

    // R6: reset pulse length and bit 0 gating
    rst_high = 0; rst_rises = 0;
    write_frame(32, 2'b01, 2'b01, 10'h00A, 16'h0001);
    repeat (40) @(negedge clk);
    chk(rst_rises == 1, "R6 rise", rst_rises, 1);
    chk(rst_high == PULSE, "R6 length", rst_high, PULSE);
    rst_high = 0; rst_rises = 0;
    write_frame(32, 2'b01, 2'b01, 10'h00A, 16'h0002);
    repeat (40) @(negedge clk);
    chk(rst_rises == 0, "R6 bit0 clear", rst_rises, 0);

    // R11: bad start field, bad opcodes, short preamble
    oe_seen = 1'b0;
    write_frame(32, 2'b00, 2'b01, 10'h00E, 16'h0F0F);
    chk(leds == 16'h00A5, "R11 bad start", leds, 16'h00A5);
    write_frame(32, 2'b01, 2'b11, 10'h00E, 16'h0F0F);
    chk(leds == 16'h00A5, "R11 opcode 11", leds, 16'h00A5);
    write_frame(32, 2'b01, 2'b00, 10'h00E, 16'h0F0F);
    chk(leds == 16'h00A5, "R11 opcode 00", leds, 16'h00A5);
    write_frame(20, 2'b01, 2'b01, 10'h00E, 16'h0F0F);
    chk(leds == 16'h00A5, "R11 short preamble", leds, 16'h00A5);
    chk(!oe_seen, "R11 line released", oe_seen, 0);

    // R9: a proper frame after the rejected ones is accepted
    write_frame(32, 2'b01, 2'b01, 10'h00E, 16'h005A);
    chk(leds == 16'h005A, "R9 R11 recovery", leds, 16'h005A);
    read_frame(10'h00E, q, ta_ok);
    chk(q == 16'h005A && ta_ok, "R8 R4 readback", q, 16'h005A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule